// File: doc/BRIEF.md
# Sticky Limit-Violation Status Register

This block gathers violation events from a set of channel limit monitors into one status register. Each monitored channel owns two sticky bits: one records a crossing of its upper limit, the other a crossing of its lower limit. Once an event pulse sets a bit, the bit holds until software clears the register. Events on other channels that arrive before that clear simply add their own bits, so the register accumulates every violation since the last clear.

Two actions clear the register. The first is a write of all ones to the status register itself; a write of any other value does nothing. The second is a configuration write with both of its two clear bits at one. A combined alert line is active whenever any status bit is set, and a parameter selects its active level. Bus decoding sits outside the block: it sees only decoded write strobes with their data.

Top module: `alert_latch_bank`

## Requirements
- R1: After reset, every status bit is 0 and the alert line is at its inactive level.
- R2: A pulse on `lo_evt[n]` sets status bit 2n, and a pulse on `hi_evt[n]` sets status bit 2n+1, at the first rising clock edge where the pulse is high. With the default four channels these are bits 0 to 7.
- R3: A set bit stays set in every cycle without a clear. Events on other channels set their own bits without disturbing bits already set.
- R4: A status write (`stat_wr` high) with `stat_wdata` equal to all ones clears every bit at that clock edge.
- R5: A configuration write (`cfg_wr` high) with `cfg_clr` equal to 2'b11 clears every bit. A configuration write with `cfg_clr` at 2'b01 or 2'b10, and a `cfg_clr` of 2'b11 without `cfg_wr`, leave the status unchanged.
- R6: A status write with any value other than all ones leaves the status unchanged.
- R7: When an event and a clear land on the same clock edge, the event's bit ends up set. All other bits are cleared.
- R8: `alert` equals `ALERT_ACTIVE_HIGH` whenever any status bit is set, and equals its complement when none is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lo_evt | input | NUM_CH | Lower-limit violation pulse per channel |
| hi_evt | input | NUM_CH | Upper-limit violation pulse per channel |
| stat_wr | input | 1 | Write strobe for the status register |
| stat_wdata | input | 2*NUM_CH | Status write data; all ones clears |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_clr | input | 2 | The two clear bits of the configuration write |
| status | output | 2*NUM_CH | Sticky status bits, low/high interleaved per channel |
| alert | output | 1 | Combined alert at the selected polarity |

## Verification
The bench builds the block with four channels and an active-high alert. With these values the status is the full 8-bit byte, so the clear code is 8'hFF, and the near-miss values 8'hFE and 8'h7F are one bit away from it in each direction. An active-high alert reads directly as "any bit set". A long pseudo-random stretch lets events, both clear paths and non-clearing writes coincide in every combination, which covers the event-beats-clear ordering as well as the directed cases.

// File: rtl/alert_latch_bank.sv
module alert_latch_bank #(
  parameter int NUM_CH = 4,
  parameter bit ALERT_ACTIVE_HIGH = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     lo_evt,
  input  logic [NUM_CH-1:0]     hi_evt,
  input  logic                  stat_wr,
  input  logic [2*NUM_CH-1:0]   stat_wdata,
  input  logic                  cfg_wr,
  input  logic [1:0]            cfg_clr,
  output logic [2*NUM_CH-1:0]   status,
  output logic                  alert
);
  localparam int W = 2 * NUM_CH;

  logic [W-1:0] evt;
  logic         wipe;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_pair
    assign evt[2*n]   = lo_evt[n];
    assign evt[2*n+1] = hi_evt[n];
  end

  assign wipe = (stat_wr && (&stat_wdata)) || (cfg_wr && (&cfg_clr));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) status <= '0;
    else        status <= (wipe ? '0 : status) | evt;

  assign alert = (|status) ? ALERT_ACTIVE_HIGH : ~ALERT_ACTIVE_HIGH;
endmodule

// File: rtl/alert_latch_bank_chk.sv
module alert_latch_bank_chk #(
  parameter int NUM_CH = 4,
  parameter bit ALERT_ACTIVE_HIGH = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_CH-1:0]   lo_evt,
  input logic [NUM_CH-1:0]   hi_evt,
  input logic                stat_wr,
  input logic [2*NUM_CH-1:0] stat_wdata,
  input logic                cfg_wr,
  input logic [1:0]          cfg_clr,
  input logic [2*NUM_CH-1:0] status,
  input logic                alert
);
  localparam int W = 2 * NUM_CH;
  logic [W-1:0] ev;
  logic         wclr, cclr;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ev
    assign ev[2*n]   = lo_evt[n];
    assign ev[2*n+1] = hi_evt[n];
  end
  assign wclr = stat_wr && (stat_wdata == {W{1'b1}});
  assign cclr = cfg_wr && (cfg_clr == 2'b11);

  p_reset_zero_r1: assert property (@(posedge clk) $rose(rst_n) |-> (status == '0));

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((status & $past(ev)) == $past(ev)));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wclr && !cclr) |=> (($past(status) & ~status) == '0));

  p_wr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wclr && ev == '0) |=> (status == '0));

  p_cfg_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cclr && ev == '0) |=> (status == '0));

  p_other_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !wclr && !cclr && ev == '0) |=> $stable(status));

  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wclr || cclr) |=> (status == $past(ev)));

  p_alert_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status != '0) |-> (alert == ALERT_ACTIVE_HIGH));
endmodule

bind alert_latch_bank alert_latch_bank_chk #(
  .NUM_CH(NUM_CH), .ALERT_ACTIVE_HIGH(ALERT_ACTIVE_HIGH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lo_evt(lo_evt), .hi_evt(hi_evt),
  .stat_wr(stat_wr), .stat_wdata(stat_wdata), .cfg_wr(cfg_wr),
  .cfg_clr(cfg_clr), .status(status), .alert(alert)
);

// File: tb/alert_latch_bank_test.sv
module alert_latch_bank_test;
  localparam int NCH = 4;
  localparam int W = 2 * NCH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] lo_evt = '0, hi_evt = '0;
  logic stat_wr = 1'b0, cfg_wr = 1'b0;
  logic [W-1:0] stat_wdata = '0;
  logic [1:0] cfg_clr = '0;
  logic [W-1:0] status;
  logic alert;

  int tests = 0, fails = 0;
  int model = 0;
  bit done = 1'b0;

  alert_latch_bank #(.NUM_CH(NCH), .ALERT_ACTIVE_HIGH(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .lo_evt(lo_evt), .hi_evt(hi_evt),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .cfg_wr(cfg_wr),
    .cfg_clr(cfg_clr), .status(status), .alert(alert)
  );

  always #5 clk = ~clk;

  task automatic check(string tag);
    tests++;
    if (int'(status) != model) begin
      fails++;
      $display("FAIL %s status actual=%02h expected=%02h", tag, status, model[W-1:0]);
    end
    tests++;
    if (alert !== (model != 0)) begin
      fails++;
      $display("FAIL R8 alert actual=%0b expected=%0b", alert, model != 0);
    end
  endtask

  task automatic step(input logic [NCH-1:0] lo, input logic [NCH-1:0] hi,
                      input logic sw, input logic [W-1:0] sd,
                      input logic cw, input logic [1:0] cc, input string tag);
    @(negedge clk);
    lo_evt = lo; hi_evt = hi; stat_wr = sw; stat_wdata = sd; cfg_wr = cw; cfg_clr = cc;
    @(posedge clk);
    if ((sw && sd == 8'hFF) || (cw && cc == 2'b11)) model = 0;
    for (int n = 0; n < NCH; n++) begin
      if (lo[n]) model = model | (1 << (2*n));
      if (hi[n]) model = model | (1 << (2*n + 1));
    end
    #2;
    lo_evt = '0; hi_evt = '0; stat_wr = 1'b0; cfg_wr = 1'b0; cfg_clr = '0; stat_wdata = '0;
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    step('0, '0, 0, '0, 0, 2'b00, "R1");
    // R2: each event line lands on its own bit
    for (int n = 0; n < NCH; n++) begin
      step(NCH'(1 << n), '0, 0, '0, 0, 2'b00, "R2");
      step('0, '0, 1, 8'hFF, 0, 2'b00, "R4");
      step('0, NCH'(1 << n), 0, '0, 0, 2'b00, "R2");
      step('0, '0, 1, 8'hFF, 0, 2'b00, "R4");
    end
    // R3: accumulation and holding
    step('0, 4'b0010, 0, '0, 0, 2'b00, "R3");
    repeat (5) step('0, '0, 0, '0, 0, 2'b00, "R3");
    step(4'b1000, '0, 0, '0, 0, 2'b00, "R3");
    step('0, 4'b0010, 0, '0, 0, 2'b00, "R3");
    // R6: non-clearing writes
    step('0, '0, 1, 8'hFE, 0, 2'b00, "R6");
    step('0, '0, 1, 8'h7F, 0, 2'b00, "R6");
    step('0, '0, 1, 8'h00, 0, 2'b00, "R6");
    step('0, '0, 1, 8'hFF, 0, 2'b00, "R4");
    // R5: configuration clear path
    step(4'b0101, 4'b1010, 0, '0, 0, 2'b00, "R5");
    step('0, '0, 0, '0, 1, 2'b01, "R5");
    step('0, '0, 0, '0, 1, 2'b10, "R5");
    step('0, '0, 0, '0, 0, 2'b11, "R5");
    step('0, '0, 0, '0, 1, 2'b11, "R5");
    // R7: event coinciding with clear
    step(4'b1111, '0, 0, '0, 0, 2'b00, "R7");
    step('0, 4'b0100, 1, 8'hFF, 0, 2'b00, "R7");
    step(4'b0001, '0, 0, '0, 1, 2'b11, "R7");
    // mixed pseudo-random stretch
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] & {4{lfsr[4]}}, lfsr[7:4] & {4{lfsr[8]}},
           lfsr[9] & lfsr[10], lfsr[11] ? 8'hFF : lfsr[7:0],
           lfsr[12] & lfsr[13], lfsr[15:14], "R7");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule